// File: doc/BRIEF.md
# Hardware Semaphore Bank with Hardware Auto-Claim

This block holds a bank of binary lock flags that several bus masters share to guard common resources. Each lock is one 32-bit word on a simple memory-mapped bus with an address, a read strobe, a write strobe, write data and read data. A read of a lock word is an atomic test-and-set. It reports whether the caller won the lock, and it marks the lock as taken in the same access. A write with bit 0 set hands the lock back.

A further word lets software name one lock for the hardware to acquire. The block then tries to claim that lock once per clock cycle until it wins. On a win it raises a level event that stays high until that lock is released or a new lock number is written. Software sees this as an "acquire in the background and tell me when done" service. A bus read always wins over a hardware attempt made in the same cycle.

Top module: `sema_bank_top`

## Requirements
- R1: After reset all eight locks are free, the auto-claim engine is idle with lock number 0, `autoTakeDone` is 0 and `busRdata` is 0.
- R2: Lock k sits at byte offset 4*k (k = 0..7) and uses bit 0; address bits [1:0] are ignored. A read of a free lock sets it taken, and in the cycle after the read strobe `busRdata` equals 1.
- R3: A read of a taken lock leaves it taken, and `busRdata` is 0 in the cycle after the read strobe.
- R4: A write to lock k with write-data bit 0 equal to 1 frees lock k. A write with bit 0 equal to 0 leaves every lock unchanged.
- R5: A write to offset 0x20 stores write-data bits [2:0] as the auto-claim lock number, clears `autoTakeDone` on the next edge and starts the engine. A read of 0x20 returns that number in bits [2:0] with zeros above, one cycle after the strobe.
- R6: While the engine is seeking, it makes one claim attempt per cycle, starting in the cycle after the number is written. A successful attempt sets the lock and raises `autoTakeDone` on that edge. If the lock is free throughout, `autoTakeDone` is therefore 1 two edges after the write.
- R7: `autoTakeDone` stays 1 until the claimed lock is freed by a bus write, which drops it on that write's edge, or until a new number is written (R5). Releases of other locks do not affect it.
- R8: When a bus read or release targets the sought lock in the same cycle as an attempt, the bus access wins and the engine retries in a later cycle.
- R9: Writing a new number while a claim is pending abandons the old lock without taking it.
- R10: A read at an unmapped offset (0x24 and above) returns 0 and changes no state. A read of the lock held by the engine returns 0 and leaves `autoTakeDone` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Byte address of the access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered, valid the cycle after the read strobe |
| autoTakeDone | output | 1 | Level event: the auto-claim engine holds its lock |

## Verification
Read data is registered, so a read result is due one cycle after the strobe. The bench drives each access at a falling edge and compares `busRdata` at the next falling edge. It compares `autoTakeDone` at that same point, because a write to the number register, a winning attempt and a release each move it on the edge that ends their cycle. A successful auto-claim therefore appears two compare points after the number write. A reference model in the bench advances once per cycle by the rules above. Directed sequences set up the collision, abandonment and held-read cases before a long seeded random run.

// File: rtl/sema_pkg.sv
package sema_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic rdSema;     // test-and-set read of a lock word
    logic relSema;    // release of a lock word
    logic rdIdx;      // read of the auto-claim number register
    logic loadIdx;    // write of the auto-claim number register
    logic autoClaim;  // engine claims its lock this cycle
  } semaStrb_t;

  typedef enum logic [1:0] {
    AT_IDLE = 2'd0,
    AT_SEEK = 2'd1,
    AT_HELD = 2'd2
  } atState_t;

endpackage

// File: rtl/sema_ctrl.sv
module sema_ctrl
  import sema_pkg::*;
#(
  parameter int NUM_SEMA = 8,
  parameter int ADDR_W   = 6,
  localparam int IDX_W   = $clog2(NUM_SEMA),
  localparam int WORD_W  = ADDR_W - 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busRd,
  input  logic                busWr,
  input  logic                busWbit0,
  input  logic [NUM_SEMA-1:0] semaFlags,
  input  logic [IDX_W-1:0]    atIdx,
  output semaStrb_t           strb,
  output logic [IDX_W-1:0]    semaSel,
  output logic                autoTakeDone
);

  logic [WORD_W-1:0] wordIdx;
  logic              isSemaWord;
  logic              isAtWord;
  logic              hitAt;
  logic              busOnAt;
  logic              unusedAddr;
  atState_t          atState;
  atState_t          atNext;

  assign wordIdx    = busAddr[ADDR_W-1:2];
  assign unusedAddr = ^busAddr[1:0];
  assign isSemaWord = wordIdx < WORD_W'(NUM_SEMA);
  assign isAtWord   = wordIdx == WORD_W'(NUM_SEMA);
  assign semaSel    = wordIdx[IDX_W-1:0];
  assign hitAt      = semaSel == atIdx;

  always_comb begin
    strb.rdSema  = busRd && isSemaWord;
    strb.relSema = busWr && isSemaWord && busWbit0;
    strb.rdIdx   = busRd && isAtWord;
    strb.loadIdx = busWr && isAtWord;
  end

  // Bus access to the sought lock takes precedence over the engine
  assign busOnAt = (strb.rdSema || strb.relSema) && hitAt;

  always_comb begin
    strb.autoClaim = (atState == AT_SEEK) && !strb.loadIdx &&
                     !semaFlags[atIdx] && !busOnAt;
  end

  always_comb begin
    atNext = atState;
    if (strb.loadIdx) begin
      atNext = AT_SEEK;
    end else begin
      unique case (atState)
        AT_SEEK: if (strb.autoClaim) atNext = AT_HELD;
        AT_HELD: if (strb.relSema && hitAt) atNext = AT_IDLE;
        default: atNext = atState;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) atState <= AT_IDLE;
    else       atState <= atNext;
  end

  assign autoTakeDone = atState == AT_HELD;

endmodule

// File: rtl/sema_dp.sv
module sema_dp
  import sema_pkg::*;
#(
  parameter int NUM_SEMA = 8,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_SEMA)
) (
  input  logic                clk,
  input  logic                rstN,
  input  semaStrb_t           strb,
  input  logic [IDX_W-1:0]    semaSel,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [NUM_SEMA-1:0] semaFlags,
  output logic [IDX_W-1:0]    atIdx,
  output logic [DATA_W-1:0]   busRdata
);

  logic unusedWdata;
  assign unusedWdata = ^busWdata[DATA_W-1:IDX_W];

  for (genvar i = 0; i < NUM_SEMA; i++) begin : g_flag
    logic selHit;
    logic atHit;
    assign selHit = semaSel == IDX_W'(i);
    assign atHit  = atIdx == IDX_W'(i);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        semaFlags[i] <= 1'b0;
      end else if (strb.relSema && selHit) begin
        semaFlags[i] <= 1'b0;
      end else if ((strb.rdSema && selHit) || (strb.autoClaim && atHit)) begin
        semaFlags[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             atIdx <= '0;
    else if (strb.loadIdx) atIdx <= busWdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (strb.rdSema) begin
      busRdata <= {{(DATA_W-1){1'b0}}, ~semaFlags[semaSel]};
    end else if (strb.rdIdx) begin
      busRdata <= {{(DATA_W-IDX_W){1'b0}}, atIdx};
    end else begin
      busRdata <= '0;
    end
  end

endmodule

// File: rtl/sema_bank_top.sv
module sema_bank_top
  import sema_pkg::*;
#(
  parameter int NUM_SEMA = 8,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_SEMA)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              autoTakeDone
);

  semaStrb_t           strb;
  logic [IDX_W-1:0]    semaSel;
  logic [IDX_W-1:0]    atIdx;
  logic [NUM_SEMA-1:0] semaFlags;

  sema_ctrl #(.NUM_SEMA(NUM_SEMA), .ADDR_W(ADDR_W)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .busAddr      (busAddr),
    .busRd        (busRd),
    .busWr        (busWr),
    .busWbit0     (busWdata[0]),
    .semaFlags    (semaFlags),
    .atIdx        (atIdx),
    .strb         (strb),
    .semaSel      (semaSel),
    .autoTakeDone (autoTakeDone)
  );

  sema_dp #(.NUM_SEMA(NUM_SEMA), .DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .semaSel   (semaSel),
    .busWdata  (busWdata),
    .semaFlags (semaFlags),
    .atIdx     (atIdx),
    .busRdata  (busRdata)
  );

endmodule

// File: rtl/sema_bank_chk.sv
module sema_bank_chk #(
  parameter int NUM_SEMA = 8,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_SEMA),
  localparam int WORD_W  = ADDR_W - 2
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busRd,
  input logic                busWr,
  input logic [DATA_W-1:0]   busWdata,
  input logic [DATA_W-1:0]   busRdata,
  input logic                autoTakeDone,
  input logic [NUM_SEMA-1:0] semaFlags,
  input logic [IDX_W-1:0]    atIdx
);

  logic [WORD_W-1:0] cWord;
  logic [IDX_W-1:0]  cSel;
  logic              cSema;
  logic              cAt;
  logic              unusedChk;

  assign cWord     = busAddr[ADDR_W-1:2];
  assign cSel      = cWord[IDX_W-1:0];
  assign cSema     = cWord < WORD_W'(NUM_SEMA);
  assign cAt       = cWord == WORD_W'(NUM_SEMA);
  assign unusedChk = ^{busAddr[1:0], busWdata[DATA_W-1:1]};

  AST_GRANT_ON_FREE: assert property (@(posedge clk) disable iff (!rstN)
    busRd && !busWr && cSema && !semaFlags[cSel] |=> busRdata == DATA_W'(1) && semaFlags[$past(cSel)]); // R2

  AST_DENY_ON_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    busRd && !busWr && cSema && semaFlags[cSel] |=> busRdata == '0 && semaFlags[$past(cSel)]); // R3

  AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rstN)
    busWr && !busRd && cSema && busWdata[0] |=> !semaFlags[$past(cSel)]); // R4

  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    busWr && !busRd && cSema && !busWdata[0] && semaFlags[cSel] |=> semaFlags[$past(cSel)]); // R4

  AST_LOAD_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    busWr && cAt |=> !autoTakeDone); // R5

  AST_DONE_OWNS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    autoTakeDone |-> semaFlags[atIdx]); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRd && !cSema && !cAt |=> busRdata == '0); // R10

endmodule

bind sema_bank_top sema_bank_chk #(
  .NUM_SEMA (NUM_SEMA),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .busAddr      (busAddr),
  .busRd        (busRd),
  .busWr        (busWr),
  .busWdata     (busWdata),
  .busRdata     (busRdata),
  .autoTakeDone (autoTakeDone),
  .semaFlags    (semaFlags),
  .atIdx        (atIdx)
);

// File: tb/sema_bank_top_tb.sv
`timescale 1ns/1ps
module sema_bank_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        autoTakeDone;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // Reference model state
  logic [7:0] mFlags = '0;
  logic [2:0] mAt    = '0;
  logic       mPend  = 1'b0;
  logic       mDone  = 1'b0;

  always #4 clk = ~clk;

  sema_bank_top dut_i (
    .clk (clk), .rstN (rstN), .busAddr (busAddr), .busRd (busRd),
    .busWr (busWr), .busWdata (busWdata), .busRdata (busRdata),
    .autoTakeDone (autoTakeDone)
  );

  function automatic logic [31:0] expRead(logic rd, logic [3:0] word);
    if (!rd)       return 32'd0;
    if (word < 8)  return {31'd0, ~mFlags[word[2:0]]};
    if (word == 8) return {29'd0, mAt};
    return 32'd0;
  endfunction

  function automatic logic claimOk(logic rd, logic wr, logic [3:0] word, logic wb0);
    logic busOnAt;
    busOnAt = word < 8 && word[2:0] == mAt && (rd || (wr && wb0));
    return mPend && !(wr && word == 8) && !mFlags[mAt] && !busOnAt;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(logic rd, logic wr, logic [5:0] addr, logic [31:0] wd);
    logic [3:0]  word;
    logic [31:0] eRd;
    logic        claim;
    string       rTag;
    string       dTag;
    word = addr[5:2];
    busRd = rd; busWr = wr; busAddr = addr; busWdata = wd;
    eRd   = expRead(rd, word);
    claim = claimOk(rd, wr, word, wd[0]);
    if (rd && word < 8)
      rTag = (mPend && word[2:0] == mAt && !mFlags[mAt]) ? "R8" :
             (mDone && word[2:0] == mAt) ? "R10" :
             mFlags[word[2:0]] ? "R3" : "R2";
    else if (rd && word == 8) rTag = "R5";
    else if (rd)              rTag = "R10";
    else                      rTag = "R4";
    if (wr && word == 8)      dTag = mPend ? "R9" : "R5";
    else if (claim)           dTag = "R6";
    else                      dTag = "R7";
    // model next state
    if (rd && word < 8) mFlags[word[2:0]] = 1'b1;
    if (claim) mFlags[mAt] = 1'b1;
    if (wr && word < 8 && wd[0]) begin
      if (mDone && word[2:0] == mAt) mDone = 1'b0;
      mFlags[word[2:0]] = 1'b0;
    end
    if (claim) begin mPend = 1'b0; mDone = 1'b1; end
    if (wr && word == 8) begin mAt = wd[2:0]; mPend = 1'b1; mDone = 1'b0; end
    @(posedge clk);
    @(negedge clk);
    busRd = 1'b0; busWr = 1'b0;
    check(rTag, busRdata, eRd);
    check(dTag, {31'd0, autoTakeDone}, {31'd0, mDone});
  endtask

  task automatic rdS(int k);           step(1'b1, 1'b0, 6'(k * 4), 32'd0); endtask
  task automatic relS(int k);          step(1'b0, 1'b1, 6'(k * 4), 32'd1); endtask
  task automatic setAt(int k);         step(1'b0, 1'b1, 6'h20, 32'(k)); endtask
  task automatic idle();               step(1'b0, 1'b0, 6'h00, 32'd0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(negedge clk);
    // R1: reset state visible at the ports
    check("R1", busRdata, 32'd0);
    check("R1", {31'd0, autoTakeDone}, 32'd0);
    rstN = 1'b1;
    idle();
    step(1'b1, 1'b0, 6'h20, 32'd0);           // R1/R5: number 0 after reset
    for (int k = 0; k < 8; k++) rdS(k);       // R1/R2: all free
    for (int k = 0; k < 8; k++) rdS(k);       // R3: now taken
    step(1'b0, 1'b1, 6'h0C, 32'hFFFF_FFFE);   // R4: write 0 ignored
    rdS(3);
    for (int k = 0; k < 8; k++) relS(k);      // R4
    step(1'b1, 1'b0, 6'h0B, 32'd0);           // R2: low bits ignored
    relS(2);
    // R6/R10/R7: claim a free lock
    setAt(5); idle(); idle();
    rdS(5);                                   // R10: held read returns 0
    rdS(2); relS(2);                          // R7: other lock no effect
    step(1'b1, 1'b0, 6'h20, 32'd0);           // R5: readback 5
    relS(5); idle();                          // R7: release drops done
    // R6: blocked until released
    rdS(6); setAt(6); idle(); idle(); relS(6); idle(); relS(6); idle();
    // R8: bus read beats the engine
    rdS(1); setAt(1); relS(1); rdS(1); idle(); relS(1); idle(); idle(); relS(1);
    // R9: abandon pending number
    rdS(4); setAt(4); setAt(7); idle(); relS(4); rdS(4); relS(4); relS(7);
    // R10: unmapped reads
    step(1'b1, 1'b0, 6'h24, 32'd0); step(1'b1, 1'b0, 6'h3C, 32'd0);
    step(1'b0, 1'b1, 6'h30, 32'd1);
    for (int k = 0; k < 8; k++) rdS(k);
    for (int k = 0; k < 8; k++) relS(k);
    // Seeded random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [3:0] w;
      logic [31:0] d;
      op = $urandom_range(0, 9);
      w  = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) < 2) w = 4'($urandom_range(0, 8));
      d  = $urandom;
      if ($urandom_range(0, 3) != 0) d[0] = 1'b1;
      if (op < 5)      step(1'b1, 1'b0, {w, 2'($urandom_range(0, 3))}, 32'd0);
      else if (op < 8) step(1'b0, 1'b1, {w, 2'b00}, d);
      else             idle();
    end
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule